// File: doc/BRIEF.md
# Task-File PIO Command Engine

This block lets a local microcontroller hand off task-file reads of an attached ATAPI device to hardware. Firmware writes an 8-bit command code. The engine then acts as a PIO bus master and runs 16-bit read cycles against the device's eight task-file registers. Offset 0 is the data port and offset 7 is the status register. Each word read is stored in a small capture memory, which firmware reads back through its own port.

The engine runs three commands. The data-port read uses a byte count that firmware supplies with the command, and turns it into whole 16-bit words. The busy poll reads the status register again and again until its busy flag drops. The register scan reads the whole task-file block, or only the register selected by an index input. The poll and the scan end by setting an interrupt status bit. A mask gates only the interrupt line, so firmware can still poll the status bit while the line is masked.

Top module: `tf_pio_engine`

## Requirements
- R1: After a synchronous reset the engine is idle. `busy`, `pio_rd`, `rd_vld`, `irq_stat` and `irq_out` are all low.
- R2: Code 0Ah reads offset 0 exactly ceil(N/2) times, where N is `xfer_bytes` sampled with the command write. Each word read appears on `rd_word` with a one-cycle `rd_vld` pulse. N = 0 starts no access. This command does not touch `irq_stat`.
- R3: Code 0Bh reads offset 7 repeatedly and stops after the first returned word whose bit 7 (busy flag) is 0. That final word is captured at offset 7.
- R4: Code 0Ch with `tf_index` = 0 reads offsets 1, 2, 3, 4, 5, 6 once each, in that order, and never reads offset 0 or 7.
- R5: Code 0Ch with a nonzero `tf_index` reads only that offset, exactly once.
- R6: When code 0Bh or 0Ch completes, `irq_stat` is set. `irq_out` equals `irq_stat` AND NOT `irq_mask` one clock later. The mask never keeps `irq_stat` from setting.
- R7: A one-cycle high on `irq_clr` clears `irq_stat` at the next edge. A completion in the same cycle wins over the clear.
- R8: Every code other than 0Ah, 0Bh and 0Ch is ignored: no PIO cycle starts and `busy` stays low. This includes the reserved codes 02h–05h and 0Dh.
- R9: A command written while `busy` is high is ignored. The running command completes unchanged.
- R10: `busy` and `pio_rd` rise in the cycle after an accepted write. `pio_rd` holds with a stable `pio_addr` until `pio_rdy` is sampled high. At that edge `pio_rdata` is taken, and `pio_rd` then drops for at least one cycle.
- R11: `cap_data` shows the last word captured for offset `cap_addr` one clock after `cap_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| tf_index | input | 3 | Register select for the scan (0 = full scan) |
| xfer_bytes | input | 16 | Byte count for the data-port read |
| irq_mask | input | 1 | Masks `irq_out` when high |
| irq_clr | input | 1 | Write-one-to-clear for `irq_stat` |
| pio_rd | output | 1 | PIO read strobe |
| pio_addr | output | 3 | Task-file register offset |
| pio_rdata | input | 16 | PIO read data |
| pio_rdy | input | 1 | Device ready; completes the access |
| busy | output | 1 | Command in progress |
| rd_vld | output | 1 | Data-port word valid pulse |
| rd_word | output | 16 | Data-port word |
| cap_addr | input | 3 | Capture memory read offset |
| cap_data | output | 16 | Capture memory read data |
| irq_stat | output | 1 | Completion status bit |
| irq_out | output | 1 | Masked interrupt line |

## Verification
A wrong sequencer state shows up on the PIO bus within the next access. Possible symptoms are a wrong offset, an extra or missing strobe, or a poll that runs past the first idle status word. The bench logs every access the device model serves and compares the log with the expected list. A fault in the completion or mask logic shows on `irq_stat` or `irq_out` within two clocks after `busy` falls. A capture fault shows on `cap_data` one clock after the offset is applied.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  localparam logic [7:0] CODE_DATA = 8'h0A;
  localparam logic [7:0] CODE_POLL = 8'h0B;
  localparam logic [7:0] CODE_SCAN = 8'h0C;
  localparam int OFS_DATA   = 0;
  localparam int OFS_STAT   = 7;
  localparam int SCAN_FIRST = 1;
  localparam int SCAN_LAST  = 6;

  typedef enum logic [1:0] {K_NONE, K_DATA, K_POLL, K_SCAN} kind_t;
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP} seq_st_t;
endpackage

// File: rtl/tfe_cmd_decode.sv
module tfe_cmd_decode
  import tfe_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  output kind_t             kind
);
  always_comb begin
    unique case (code)
      CODE_W'(CODE_DATA): kind = K_DATA;
      CODE_W'(CODE_POLL): kind = K_POLL;
      CODE_W'(CODE_SCAN): kind = K_SCAN;
      default:            kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/tfe_seq.sv
module tfe_seq
  import tfe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 16,
  parameter int BSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] sel_index,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              pio_rdy,
  input  logic [DATA_W-1:0] pio_rdata,
  output logic              pio_rd,
  output logic [ADDR_W-1:0] pio_addr,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              word_vld,
  output logic [DATA_W-1:0] word,
  output logic              done
);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(SCAN_FIRST);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(SCAN_LAST);

  seq_st_t           st;
  kind_t             cur;
  logic              single;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  words_in;
  logic              last;

  assign words_in = (nbytes >> 1) + CNT_W'(nbytes[0]);

  always_comb begin
    unique case (cur)
      K_DATA:  last = (remain == CNT_W'(1));
      K_POLL:  last = !pio_rdata[BSY_BIT];
      K_SCAN:  last = single || (pio_addr == A_LAST);
      default: last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cur      <= K_NONE;
      single   <= 1'b0;
      remain   <= '0;
      pio_rd   <= 1'b0;
      pio_addr <= '0;
      busy     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      word_vld <= 1'b0;
      word     <= '0;
      done     <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      word_vld <= 1'b0;
      done     <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            cur    <= kind;
            single <= (sel_index != '0);
            unique case (kind)
              K_DATA: if (words_in != '0) begin
                remain   <= words_in;
                pio_addr <= A_DATA;
                pio_rd   <= 1'b1;
                busy     <= 1'b1;
                st       <= S_ACC;
              end
              K_POLL: begin
                pio_addr <= A_STAT;
                pio_rd   <= 1'b1;
                busy     <= 1'b1;
                st       <= S_ACC;
              end
              K_SCAN: begin
                pio_addr <= (sel_index == '0) ? A_FIRST : sel_index;
                pio_rd   <= 1'b1;
                busy     <= 1'b1;
                st       <= S_ACC;
              end
              default: ;
            endcase
          end
        end
        S_ACC: begin
          if (pio_rdy) begin
            pio_rd  <= 1'b0;
            wr_en   <= 1'b1;
            wr_addr <= pio_addr;
            wr_data <= pio_rdata;
            if (cur == K_DATA) begin
              word_vld <= 1'b1;
              word     <= pio_rdata;
              remain   <= remain - CNT_W'(1);
            end
            if (last) begin
              st   <= S_IDLE;
              busy <= 1'b0;
              done <= (cur != K_DATA);
            end else begin
              st <= S_GAP;
              if (cur == K_SCAN) pio_addr <= pio_addr + ADDR_W'(1);
            end
          end
        end
        S_GAP: begin
          pio_rd <= 1'b1;
          st     <= S_ACC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: strobe and offset held until the device answers
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (pio_rd && !pio_rdy) |=> (pio_rd && $stable(pio_addr)));
  // R10: one idle cycle after each completed access
  a_r10_gap: assert property (@(posedge clk) disable iff (rst)
    (pio_rd && pio_rdy) |=> !pio_rd);
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pio_rd);
  a_r3_poll_addr: assert property (@(posedge clk) disable iff (rst)
    (busy && cur == K_POLL) |-> (pio_addr == A_STAT));
  a_r4_scan_range: assert property (@(posedge clk) disable iff (rst)
    (pio_rd && cur == K_SCAN && !single) |-> (pio_addr >= A_FIRST && pio_addr <= A_LAST));
  a_r9_kind_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cur));
endmodule

// File: rtl/tfe_capture_ram.sv
module tfe_capture_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tfe_irq.sv
module tfe_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic stat,
  output logic irq
);
  logic stat_n;
  assign stat_n = set | (stat & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= 1'b0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_n;
      irq  <= stat_n & ~mask;
    end
  end

  a_r6_set: assert property (@(posedge clk) disable iff (rst) set |=> stat);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !stat);
  a_r6_line_needs_stat: assert property (@(posedge clk) disable iff (rst) irq |-> stat);
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (rst) $past(mask) |-> !irq);
endmodule

// File: rtl/tf_pio_engine.sv
module tf_pio_engine
  import tfe_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 16,
  parameter int BSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [ADDR_W-1:0] tf_index,
  input  logic [CNT_W-1:0]  xfer_bytes,
  input  logic              irq_mask,
  input  logic              irq_clr,
  output logic              pio_rd,
  output logic [ADDR_W-1:0] pio_addr,
  input  logic [DATA_W-1:0] pio_rdata,
  input  logic              pio_rdy,
  output logic              busy,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_word,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              irq_stat,
  output logic              irq_out
);
  kind_t             kind;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              done;

  tfe_cmd_decode #(.CODE_W(CODE_W)) u_dec (.code(cmd_code), .kind(kind));

  tfe_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BSY_BIT(BSY_BIT)
  ) u_seq (
    .clk(clk), .rst(rst), .start(cmd_we), .kind(kind),
    .sel_index(tf_index), .nbytes(xfer_bytes),
    .pio_rdy(pio_rdy), .pio_rdata(pio_rdata),
    .pio_rd(pio_rd), .pio_addr(pio_addr), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_vld(rd_vld), .word(rd_word), .done(done)
  );

  tfe_capture_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(cap_addr), .rdata(cap_data)
  );

  tfe_irq u_irq (
    .clk(clk), .rst(rst), .set(done), .clr(irq_clr), .mask(irq_mask),
    .stat(irq_stat), .irq(irq_out)
  );

  // R2: data-port reads never complete with an interrupt
  a_r2_no_irq_on_data: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !$past(irq_stat) && !irq_stat) |=> !irq_stat);
endmodule

// File: tb/tf_pio_engine_tb.sv
module tf_pio_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [2:0]  tf_index = '0;
  logic [15:0] xfer_bytes = '0;
  logic        irq_mask = 1'b0;
  logic        irq_clr = 1'b0;
  logic        pio_rd;
  logic [2:0]  pio_addr;
  logic [15:0] pio_rdata = '0;
  logic        pio_rdy = 1'b0;
  logic        busy;
  logic        rd_vld;
  logic [15:0] rd_word;
  logic [2:0]  cap_addr = '0;
  logic [15:0] cap_data;
  logic        irq_stat;
  logic        irq_out;

  always #2 clk = ~clk;

  tf_pio_engine u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .tf_index(tf_index), .xfer_bytes(xfer_bytes), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .pio_rd(pio_rd), .pio_addr(pio_addr),
    .pio_rdata(pio_rdata), .pio_rdy(pio_rdy), .busy(busy), .rd_vld(rd_vld),
    .rd_word(rd_word), .cap_addr(cap_addr), .cap_data(cap_data),
    .irq_stat(irq_stat), .irq_out(irq_out)
  );

  // device model
  logic [15:0] dev_reg [8];
  int lat = 0, wait_cnt = 0, bsy_left = 0, data_seq = 0;
  int n_acc = 0, n_words = 0;
  int log_addr [256];
  logic [15:0] log_word [256];

  function automatic logic [15:0] dev_value(input logic [2:0] a);
    if (a == 3'd0) return dev_reg[0] + 16'(data_seq);
    if (a == 3'd7) return (bsy_left > 0) ? (dev_reg[7] | 16'h0080) : (dev_reg[7] & 16'hFF7F);
    return dev_reg[a];
  endfunction

  always @(negedge clk) begin
    if (pio_rdy) pio_rdy <= 1'b0;
    else if (pio_rd) begin
      if (wait_cnt >= lat) begin
        pio_rdy   <= 1'b1;
        pio_rdata <= dev_value(pio_addr);
        log_addr[n_acc & 255] = int'(pio_addr);
        n_acc = n_acc + 1;
        if (pio_addr == 3'd0) data_seq = data_seq + 1;
        if (pio_addr == 3'd7 && bsy_left > 0) bsy_left = bsy_left - 1;
        wait_cnt = 0;
      end else wait_cnt = wait_cnt + 1;
    end
    if (rd_vld) begin
      log_word[n_words & 255] = rd_word;
      n_words = n_words + 1;
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] code, input logic [2:0] idx, input logic [15:0] nb);
    @(negedge clk);
    cmd_code = code; tf_index = idx; xfer_bytes = nb; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle;
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) check(0, "watchdog idle", guard, 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic clear_irq;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  function automatic int exp_count(input int kind, input int idx, input int nb, input int bsy);
    if (kind == 0) return (nb + 1) / 2;
    if (kind == 1) return bsy + 1;
    return (idx == 0) ? 6 : 1;
  endfunction

  function automatic int exp_addr(input int kind, input int idx, input int i);
    if (kind == 0) return 0;
    if (kind == 1) return 7;
    return (idx == 0) ? i + 1 : idx;
  endfunction

  // run one command and verify access log, words and irq
  task automatic run_cmd(input int kind, input int idx, input int nb, input int bsy, input int l, input string req);
    int base, wbase, sbase, cnt;
    logic [7:0] code;
    code = (kind == 0) ? 8'h0A : (kind == 1) ? 8'h0B : 8'h0C;
    lat = l; bsy_left = bsy;
    base = n_acc; wbase = n_words; sbase = data_seq;
    issue(code, 3'(idx), 16'(nb));
    wait_idle();
    cnt = exp_count(kind, idx, nb, bsy);
    check(n_acc - base == cnt, {req, " access count"}, n_acc - base, cnt);
    for (int i = 0; i < cnt && i < 16; i++)
      check(log_addr[(base + i) & 255] == exp_addr(kind, idx, i), {req, " access order"},
            log_addr[(base + i) & 255], exp_addr(kind, idx, i));
    if (kind == 0) begin
      check(n_words - wbase == cnt, "R2 word count", n_words - wbase, cnt);
      for (int i = 0; i < cnt && i < 16; i++)
        check(log_word[(wbase + i) & 255] == dev_reg[0] + 16'(sbase + i), "R2 word value",
              log_word[(wbase + i) & 255], dev_reg[0] + 16'(sbase + i));
      check(irq_stat == 1'b0, "R2 no irq", irq_stat, 0);
    end else begin
      check(irq_stat == 1'b1, "R6 stat set", irq_stat, 1);
      check(irq_out == !irq_mask, "R6 line vs mask", irq_out, !irq_mask);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) dev_reg[i] = 16'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!busy && !pio_rd && !rd_vld, "R1 idle after reset", {busy, pio_rd, rd_vld}, 0);
    check(!irq_stat && !irq_out, "R1 irq clear after reset", {irq_stat, irq_out}, 0);

    // R10: busy and strobe rise the cycle after the write
    lat = 2;
    issue(8'h0C, 3'd0, 16'd0);
    check(busy && pio_rd, "R10 start timing", {busy, pio_rd}, 3);
    wait_idle();
    check(irq_stat, "R6 scan completion", irq_stat, 1);
    // R11 / R4: captured values
    for (int a = 1; a <= 6; a++) begin
      @(negedge clk); cap_addr = 3'(a);
      @(negedge clk);
      check(cap_data == dev_reg[a], "R11 capture readback", cap_data, dev_reg[a]);
    end
    clear_irq();
    @(negedge clk);
    check(!irq_stat && !irq_out, "R7 clear", {irq_stat, irq_out}, 0);

    run_cmd(2, 0, 0, 0, 1, "R4");
    clear_irq();
    run_cmd(2, 3, 0, 0, 0, "R5");
    clear_irq();
    irq_mask = 1'b1;
    run_cmd(1, 0, 0, 3, 1, "R3");
    @(negedge clk); cap_addr = 3'd7; @(negedge clk);
    check(cap_data == (dev_reg[7] & 16'hFF7F), "R3 final status captured", cap_data, dev_reg[7] & 16'hFF7F);
    clear_irq();
    @(negedge clk);
    check(!irq_stat, "R7 clear while masked", irq_stat, 0);
    irq_mask = 1'b0;
    run_cmd(1, 0, 0, 0, 0, "R3");
    clear_irq();
    run_cmd(0, 0, 5, 0, 1, "R2");
    run_cmd(0, 0, 1, 0, 0, "R2");
    run_cmd(0, 0, 0, 0, 0, "R2 zero count");

    // R8: reserved and unknown codes
    begin
      logic [7:0] codes [7] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h0D, 8'h00, 8'hFF};
      foreach (codes[k]) begin
        int base;
        base = n_acc;
        issue(codes[k], 3'd0, 16'd4);
        check(!busy && !pio_rd, "R8 reserved ignored busy", {busy, pio_rd}, 0);
        repeat (3) @(negedge clk);
        check(n_acc == base, "R8 reserved no access", n_acc - base, 0);
      end
      check(!irq_stat, "R8 no irq", irq_stat, 0);
    end

    // R9: command while busy ignored
    begin
      int base;
      base = n_acc; lat = 2; bsy_left = 5;
      issue(8'h0B, 3'd0, 16'd0);
      repeat (3) @(negedge clk);
      issue(8'h0C, 3'd0, 16'd0);
      wait_idle();
      check(n_acc - base == 6, "R9 busy write ignored count", n_acc - base, 6);
      for (int i = 0; i < 6; i++)
        check(log_addr[(base + i) & 255] == 7, "R9 only poll reads", log_addr[(base + i) & 255], 7);
      clear_irq();
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind, idx, nb, bsy, l;
      kind = int'($urandom_range(0, 2));
      idx  = int'($urandom_range(0, 7));
      nb   = int'($urandom_range(0, 9));
      bsy  = int'($urandom_range(0, 4));
      l    = int'($urandom_range(0, 3));
      irq_mask = 1'($urandom);
      for (int a = 0; a < 8; a++) dev_reg[a] = 16'($urandom);
      run_cmd(kind, idx, nb, bsy, l, kind == 0 ? "R2 rand" : kind == 1 ? "R3 rand" : (idx == 0 ? "R4 rand" : "R5 rand"));
      clear_irq();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule